// File: doc/BRIEF.md
# Short Training Field Autocorrelation Detector

The block watches a stream of complex baseband samples (signed 16-bit in-phase and quadrature, qualified by a valid strobe) for the repeating short training field that opens an OFDM packet. Each accepted sample is multiplied by the conjugate of the sample taken 16 samples earlier. The products are summed over a sliding window of 16 products, and the energy of the latest 16 samples is summed alongside. The magnitude of the complex correlation is estimated without multipliers and compared against three quarters of the window energy, built from shifts so that no divider is needed.

A second screen counts the signs of the in-phase parts in the same sample window and turns away constant or one-sided signals, which also correlate strongly. Consecutive qualifying samples are counted, and a detection pulse is raised once the run reaches a programmable plateau length. The plateau length is loaded through a small write port. An external power-trigger input gates the whole decision, so repeating silence cannot cause a detection. After one pulse the block stays quiet until the trigger has been seen low.

Top module: `stf_autocorr_det`

## Requirements
- R1: After reset `detect_o` is low and the plateau length is 100.
- R2: For each valid sample x[n], the correlation is C = sum over the latest 16 valid samples m of x[m-16]·conj(x[m]), and the energy E is the sum of |x[m]|² over the same 16 samples. Samples from before reset count as zero.
- R3: The correlation magnitude is estimated as M = max(|Re C|,|Im C|) + floor(min(|Re C|,|Im C|)/4).
- R4: A sample passes the level test when M > floor(E/2) + floor(E/4).
- R5: A sample also needs more than 4 of the latest 16 in-phase values strictly positive and more than 4 strictly negative. A constant input therefore never produces a detection.
- R6: While `trig_i` is low, no detection occurs and the run counter is cleared.
- R7: The run counter increments on each valid sample that passes R4 and R5, clears on a valid sample that fails either test, and holds on cycles with `smp_valid_i` low.
- R8: If the sample that brings the run to the plateau length is taken at clock edge k, `detect_o` is high for exactly the cycle after edge k+4. A plateau of 0 behaves like 1.
- R9: After a pulse, no further pulse occurs until `trig_i` has been sampled low. Once that has happened, a new run can detect again.
- R10: A write with `cfg_we_i` high and `cfg_addr_i` = 6 loads the plateau length from the 32-bit `cfg_wdata_i`. Writes to any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration write address |
| cfg_wdata_i | input | 32 | Configuration write data |
| trig_i | input | 1 | Power trigger, enables detection while high |
| smp_valid_i | input | 1 | Sample valid strobe |
| smp_re_i | input | 16 | In-phase sample, signed |
| smp_im_i | input | 16 | Quadrature sample, signed |
| detect_o | output | 1 | One-cycle detection pulse |

## Verification
The bound checker watches four properties on every cycle:
- each pulse lasts exactly one cycle;
- every pulse traces back five edges to a sample taken with the trigger high and the strobe valid;
- no second pulse appears before the trigger has dropped.

The arithmetic cannot be seen by a property at the ports. This covers the lag-16 correlation, the max-plus-quarter-min magnitude, the three-quarter energy threshold and the sign-balance screen. Plateau programming, the ignored addresses and the exact pulse cycle are likewise out of a property's reach. Only the bench's scenarios show these: noise, exactly periodic bursts, periodic bursts rotated by a quarter turn each period, constant input, strobe gaps and plateau values of 100, 20 and 0, each compared cycle by cycle with a reference model.

// File: rtl/stf_det_pkg.sv
package stf_det_pkg;
  localparam int PLATEAU_ADDR = 6;
  localparam int PLATEAU_RST  = 100;
  localparam int MAG_LAT      = 3;

  typedef struct packed {
    logic vld;
    logic trg;
    logic sok;
  } side_t;
endpackage

// File: rtl/stf_corr_window.sv
module stf_corr_window #(
  parameter int SMP_W  = 16,
  parameter int LAG    = 16,
  parameter int WIN    = 16,
  parameter int ACC_W  = 2*SMP_W + 1 + $clog2(WIN),
  parameter int SCNT_W = $clog2(WIN + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [SMP_W-1:0] re_i,
  input  logic signed [SMP_W-1:0] im_i,
  output logic signed [ACC_W-1:0] corr_re_o,
  output logic signed [ACC_W-1:0] corr_im_o,
  output logic        [ACC_W-1:0] energy_o,
  output logic       [SCNT_W-1:0] pos_cnt_o,
  output logic       [SCNT_W-1:0] neg_cnt_o
);
  localparam int PROD_W = 2*SMP_W + 1;

  logic signed [SMP_W-1:0]  hist_re [LAG];
  logic signed [SMP_W-1:0]  hist_im [LAG];
  logic signed [PROD_W-1:0] pr_re   [WIN];
  logic signed [PROD_W-1:0] pr_im   [WIN];
  logic        [PROD_W-1:0] pr_en   [WIN];
  logic                     pos_d   [WIN];
  logic                     neg_d   [WIN];

  logic signed [PROD_W-1:0] a, b, c, d, p_re, p_im, p_en;
  logic        [PROD_W-1:0] p_en_u;
  logic new_pos, new_neg;

  // x[n-16] * conj(x[n])
  always_comb begin
    a       = PROD_W'(hist_re[LAG-1]);
    b       = PROD_W'(hist_im[LAG-1]);
    c       = PROD_W'(re_i);
    d       = PROD_W'(im_i);
    p_re    = a*c + b*d;
    p_im    = b*c - a*d;
    p_en    = c*c + d*d;
    p_en_u  = p_en;
    new_pos = (re_i > 0);
    new_neg = re_i[SMP_W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LAG; i++) begin
        hist_re[i] <= '0;
        hist_im[i] <= '0;
      end
      for (int i = 0; i < WIN; i++) begin
        pr_re[i] <= '0;
        pr_im[i] <= '0;
        pr_en[i] <= '0;
        pos_d[i] <= 1'b0;
        neg_d[i] <= 1'b0;
      end
      corr_re_o <= '0;
      corr_im_o <= '0;
      energy_o  <= '0;
      pos_cnt_o <= '0;
      neg_cnt_o <= '0;
    end else if (valid_i) begin
      corr_re_o <= corr_re_o + ACC_W'(p_re) - ACC_W'(pr_re[WIN-1]);
      corr_im_o <= corr_im_o + ACC_W'(p_im) - ACC_W'(pr_im[WIN-1]);
      energy_o  <= energy_o + ACC_W'(p_en_u) - ACC_W'(pr_en[WIN-1]);
      pos_cnt_o <= pos_cnt_o + SCNT_W'(new_pos) - SCNT_W'(pos_d[WIN-1]);
      neg_cnt_o <= neg_cnt_o + SCNT_W'(new_neg) - SCNT_W'(neg_d[WIN-1]);
      for (int i = LAG-1; i > 0; i--) begin
        hist_re[i] <= hist_re[i-1];
        hist_im[i] <= hist_im[i-1];
      end
      hist_re[0] <= re_i;
      hist_im[0] <= im_i;
      for (int i = WIN-1; i > 0; i--) begin
        pr_re[i] <= pr_re[i-1];
        pr_im[i] <= pr_im[i-1];
        pr_en[i] <= pr_en[i-1];
        pos_d[i] <= pos_d[i-1];
        neg_d[i] <= neg_d[i-1];
      end
      pr_re[0] <= p_re;
      pr_im[0] <= p_im;
      pr_en[0] <= p_en_u;
      pos_d[0] <= new_pos;
      neg_d[0] <= new_neg;
    end
  end
endmodule

// File: rtl/stf_mag_est.sv
module stf_mag_est #(
  parameter int IN_W  = 37,
  parameter int OUT_W = IN_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic signed [IN_W-1:0] re_i,
  input  logic signed [IN_W-1:0] im_i,
  output logic       [OUT_W-1:0] mag_o
);
  logic [IN_W-1:0] abs_re_q, abs_im_q, max_q, min_q;

  // three stages: abs, sort, max + min/4
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abs_re_q <= '0;
      abs_im_q <= '0;
      max_q    <= '0;
      min_q    <= '0;
      mag_o    <= '0;
    end else begin
      abs_re_q <= re_i[IN_W-1] ? IN_W'(-re_i) : IN_W'(re_i);
      abs_im_q <= im_i[IN_W-1] ? IN_W'(-im_i) : IN_W'(im_i);
      if (abs_re_q >= abs_im_q) begin
        max_q <= abs_re_q;
        min_q <= abs_im_q;
      end else begin
        max_q <= abs_im_q;
        min_q <= abs_re_q;
      end
      mag_o <= OUT_W'(max_q) + OUT_W'(min_q >> 2);
    end
  end
endmodule

// File: rtl/stf_plateau_ctrl.sv
module stf_plateau_ctrl
  import stf_det_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              vld_i,
  input  logic              trg_i,
  input  logic              qual_i,
  output logic              detect_o
);
  logic [DATA_W-1:0] plat_q, cnt_q, cnt_inc;
  logic              armed_q;

  assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      plat_q   <= DATA_W'(PLATEAU_RST);
      cnt_q    <= '0;
      armed_q  <= 1'b1;
      detect_o <= 1'b0;
    end else begin
      if (cfg_we_i && cfg_addr_i == ADDR_W'(PLATEAU_ADDR)) plat_q <= cfg_wdata_i;
      detect_o <= 1'b0;
      if (!trg_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (vld_i) begin
        if (qual_i) begin
          cnt_q <= cnt_inc;
          if (armed_q && cnt_inc >= plat_q) begin
            detect_o <= 1'b1;
            armed_q  <= 1'b0;
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/stf_autocorr_det.sv
module stf_autocorr_det
  import stf_det_pkg::*;
#(
  parameter int SMP_W  = 16,
  parameter int LAG    = 16,
  parameter int WIN    = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              trig_i,
  input  logic              smp_valid_i,
  input  logic [SMP_W-1:0]  smp_re_i,
  input  logic [SMP_W-1:0]  smp_im_i,
  output logic              detect_o
);
  localparam int ACC_W    = 2*SMP_W + 1 + $clog2(WIN);
  localparam int MAG_W    = ACC_W + 1;
  localparam int SCNT_W   = $clog2(WIN + 1);
  localparam int SIGN_MIN = WIN / 4;

  logic signed [ACC_W-1:0]  corr_re, corr_im;
  logic        [ACC_W-1:0]  energy, thr_c;
  logic        [SCNT_W-1:0] pos_cnt, neg_cnt;
  logic        [MAG_W-1:0]  mag;
  logic                     sign_ok, qual;
  logic                     s1_vld_q, s1_trg_q;
  side_t                    side_q [MAG_LAT];
  logic        [ACC_W-1:0]  thr_q  [MAG_LAT];

  stf_corr_window #(
    .SMP_W(SMP_W), .LAG(LAG), .WIN(WIN), .ACC_W(ACC_W), .SCNT_W(SCNT_W)
  ) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (smp_valid_i),
    .re_i     (smp_re_i),
    .im_i     (smp_im_i),
    .corr_re_o(corr_re),
    .corr_im_o(corr_im),
    .energy_o (energy),
    .pos_cnt_o(pos_cnt),
    .neg_cnt_o(neg_cnt)
  );

  stf_mag_est #(.IN_W(ACC_W), .OUT_W(MAG_W)) u_mag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .re_i  (corr_re),
    .im_i  (corr_im),
    .mag_o (mag)
  );

  // 0.75 * energy, shift-only
  assign thr_c   = (energy >> 1) + (energy >> 2);
  assign sign_ok = (pos_cnt > SCNT_W'(SIGN_MIN)) && (neg_cnt > SCNT_W'(SIGN_MIN));

  // sideband delayed to line up with the magnitude pipeline
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      s1_trg_q <= 1'b0;
      for (int i = 0; i < MAG_LAT; i++) begin
        side_q[i] <= '0;
        thr_q[i]  <= '0;
      end
    end else begin
      s1_vld_q  <= smp_valid_i;
      s1_trg_q  <= trig_i;
      side_q[0] <= '{vld: s1_vld_q, trg: s1_trg_q, sok: sign_ok};
      thr_q[0]  <= thr_c;
      for (int i = 1; i < MAG_LAT; i++) begin
        side_q[i] <= side_q[i-1];
        thr_q[i]  <= thr_q[i-1];
      end
    end
  end

  assign qual = side_q[MAG_LAT-1].sok && (mag > MAG_W'(thr_q[MAG_LAT-1]));

  stf_plateau_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .vld_i      (side_q[MAG_LAT-1].vld),
    .trg_i      (side_q[MAG_LAT-1].trg),
    .qual_i     (qual),
    .detect_o   (detect_o)
  );
endmodule

// File: rtl/stf_autocorr_det_chk.sv
module stf_autocorr_det_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic trig_i,
  input logic smp_valid_i,
  input logic detect_o
);
  logic [3:0] trg_hist;
  logic       blocked;

  // trg_hist[3] is the trigger seen by the control stage at this edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trg_hist <= '0;
      blocked  <= 1'b0;
    end else begin
      trg_hist <= {trg_hist[2:0], trig_i};
      if (!trg_hist[3])  blocked <= 1'b0;
      else if (detect_o) blocked <= 1'b1;
    end
  end

  a_r8_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |=> !detect_o);

  a_r6_trig_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |-> $past(trig_i, 5));

  a_r7_valid_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |-> $past(smp_valid_i, 5));

  a_r9_holdoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked |-> !detect_o);
endmodule

bind stf_autocorr_det stf_autocorr_det_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trig_i     (trig_i),
  .smp_valid_i(smp_valid_i),
  .detect_o   (detect_o)
);

// File: tb/stf_autocorr_det_tb_top.sv
module stf_autocorr_det_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        trig = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_re = '0;
  logic [15:0] smp_im = '0;
  logic        detect_o;

  always #5 clk = ~clk;

  stf_autocorr_det dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .trig_i(trig), .smp_valid_i(smp_valid),
    .smp_re_i(smp_re), .smp_im_i(smp_im), .detect_o(detect_o)
  );

  int n_chk = 0, n_fail = 0, hits = 0, gi = 0, n_s = 0;
  string tag = "R1";
  longint xr [0:16383];
  longint xi [0:16383];
  int bre [16];
  int bim [16];
  // reference model state
  longint m_cnt = 0, m_plat = 100;
  bit m_armed = 1, m_det = 0;
  bit evv [4] = '{0, 0, 0, 0};
  bit evt [4] = '{0, 0, 0, 0};
  bit evq [4] = '{0, 0, 0, 0};

  function automatic bit qualify(input int n);
    longint cr = 0, ci = 0, e = 0, a, b, c, d, ar, ai, mx, mn, mag;
    int pc = 0, nc = 0;
    for (int m = n - 15; m <= n; m++) begin
      if (m < 0) continue;
      c = xr[m]; d = xi[m];
      a = (m >= 16) ? xr[m-16] : 0;
      b = (m >= 16) ? xi[m-16] : 0;
      cr += a*c + b*d;
      ci += b*c - a*d;
      e  += c*c + d*d;
      if (c > 0) pc++;
      if (c < 0) nc++;
    end
    ar = (cr < 0) ? -cr : cr;
    ai = (ci < 0) ? -ci : ci;
    mx = (ar >= ai) ? ar : ai;
    mn = (ar >= ai) ? ai : ar;
    mag = mx + (mn >> 2);
    return (pc > 4) && (nc > 4) && (mag > (e >> 1) + (e >> 2));
  endfunction

  task automatic model_edge(input bit v, input int re, input int im, input bit t);
    bit q = 0;
    m_det = 0;
    if (!evt[3]) begin
      m_cnt = 0; m_armed = 1;
    end else if (evv[3]) begin
      if (evq[3]) begin
        m_cnt++;
        if (m_armed && m_cnt >= m_plat) begin m_det = 1; m_armed = 0; end
      end else m_cnt = 0;
    end
    if (cfg_we && cfg_addr == 8'd6) m_plat = longint'(cfg_wdata);
    if (v) begin
      xr[n_s] = re; xi[n_s] = im;
      q = qualify(n_s);
      n_s++;
    end
    for (int i = 3; i > 0; i--) begin
      evv[i] = evv[i-1]; evt[i] = evt[i-1]; evq[i] = evq[i-1];
    end
    evv[0] = v; evt[0] = t; evq[0] = q;
  endtask

  task automatic step(input bit v, input int re, input int im, input bit t);
    smp_valid = v; smp_re = 16'(re); smp_im = 16'(im); trig = t;
    @(posedge clk);
    model_edge(v, re, im, t);
    @(negedge clk);
    n_chk++;
    if (detect_o !== m_det) begin
      n_fail++;
      $display("FAIL %s: detect_o=%0b expected %0b at sample %0d", tag, detect_o, m_det, n_s);
    end
    if (detect_o) hits++;
  endtask

  // mode 0 noise, 1 periodic, 2 periodic rotated by j each period, 3 constant
  task automatic feed(input int mode, input bit t, input int n, input bit gaps);
    for (int k = 0; k < n; k++) begin
      bit v;
      int re, im, tmp, rot;
      v = gaps ? (($urandom % 4) != 0) : 1'b1;
      re = int'($urandom % 4001) - 2000;
      im = int'($urandom % 4001) - 2000;
      if (mode == 3) begin re = 1200; im = 0; end
      if ((mode == 1 || mode == 2) && v) begin
        re = bre[gi % 16]; im = bim[gi % 16];
        rot = (mode == 2) ? (gi / 16) % 4 : 0;
        for (int r = 0; r < rot; r++) begin tmp = re; re = -im; im = tmp; end
        gi++;
      end
      step(v, re, im, t);
    end
  endtask

  task automatic cfg_write(input int addr, input int data, input bit t);
    cfg_we = 1'b1; cfg_addr = 8'(addr); cfg_wdata = 32'(data);
    step(1'b0, 0, 0, t);
    cfg_we = 1'b0;
  endtask

  task automatic expect_hits(input int exp, input string what);
    n_chk++;
    if (hits != exp) begin
      n_fail++;
      $display("FAIL %s: detections %0d expected %0d", what, hits, exp);
    end
    hits = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) begin
      bre[i] = ((i % 2) ? 1 : -1) * (500 + int'($urandom % 1500));
      bim[i] = ((i % 2) ? -1 : 1) * (300 + int'($urandom % 1500));
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (detect_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: detect_o=%0b expected 0 in reset", detect_o);
    end
    rst_ni = 1'b1;

    tag = "R1 R2 idle"; feed(0, 0, 20, 0);           expect_hits(0, "R1 idle");
    tag = "R2 R4 noise"; feed(0, 1, 200, 0);         expect_hits(0, "R2 noise");
    tag = "R4 R8 periodic default plateau R1"; feed(1, 1, 300, 0);
    expect_hits(1, "R8 periodic");
    tag = "R6 trigger low"; feed(1, 0, 300, 0);      expect_hits(0, "R6 trigger low");
    tag = "R5 constant"; feed(3, 1, 200, 0);         expect_hits(0, "R5 constant");
    tag = "R10 other address ignored";
    cfg_write(7, 5, 1); feed(1, 1, 180, 0);          expect_hits(1, "R10 addr 7 ignored");
    tag = "R3 R7 R10 rotated with gaps plateau 20";
    cfg_write(6, 20, 0); feed(1, 0, 8, 0); feed(2, 1, 250, 1);
    expect_hits(1, "R7 gaps");
    tag = "R9 hold-off"; feed(2, 1, 300, 0);         expect_hits(0, "R9 hold-off");
    tag = "R9 re-arm"; feed(1, 0, 8, 0); feed(1, 1, 100, 0);
    expect_hits(1, "R9 re-arm");
    tag = "R8 R10 plateau zero";
    cfg_write(6, 0, 0); feed(1, 0, 8, 0); feed(1, 1, 40, 0);
    expect_hits(1, "R8 plateau 0");
    tag = "R2 R3 R4 R5 R6 R7 random";
    cfg_write(6, 12, 0);
    for (int s = 0; s < 60; s++) begin
      feed(int'($urandom % 4), ($urandom % 4) != 0, 50, ($urandom % 2) == 1);
    end
    hits = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule